// File: doc/BRIEF.md
# Ring DMA Interrupt Flag and Control Register

This block holds the interrupt status word and the DMA control word of a ring-based Ethernet DMA engine. Single-cycle event pulses from the transmit and receive engines set sticky flags. Software clears a flag by writing a one to its bit. The same read word also carries live copies of the receive and transmit ring read pointers and the sequence number of the message at the head of the queue. A latched multicast hash select bit sits in that word as well.

The control word holds the transmit and receive enables, the two interrupt enables, the receive FIFO depth and the receive data offset. The block sets a receive threshold flag on every clock edge where receive is enabled and the FIFO entry count differs from the programmed depth. Three error flags are fatal: while one is set, the DMA direction it affects is held stopped. A single registered interrupt line combines the flags with their enables.

Top module: `dmaint_regs`

## Requirements
- R1: During and after synchronous reset, flags, control word, hash bit and `irq` are all 0, and so are `tx_dma_run` and `rx_dma_run`.
- R2: An event pulse on `evt_pulse[b]` sets flag b at that clock edge, and the flag then stays set until it is cleared. The flag order is: 0 tx ring empty, 1 tx packet sent, 2 link failure, 3 memory error, 4 tx abort, 5 rx threshold, 6 rx underflow, 7 rx overflow. `status_word[7:0]` shows the flags.
- R3: A write with `reg_sel`=0 clears each flag whose `reg_wdata` bit is 1 and leaves flags whose bit is 0 unchanged.
- R4: `status_word` shows the current inputs with no delay: `rx_rd_ptr` on [12:8], zeros on [15:13], `tx_rd_ptr` on [24:16], `head_seq` on [29:25], and 0 on [31].
- R5: Flag 5 is set at each edge where receive enable (control bit 15) is 1 and `fifo_level` differs from the depth field (control bits 8:4). `evt_pulse[5]` has no effect.
- R6: `status_word[30]` loads `hash_sel` at each edge while receive enable is set, and holds its value otherwise.
- R7: A write with `reg_sel`=1 loads `ctrl_word` with the written bits 0 (tx interrupt enable), 1 (tx enable), 8:4 (depth), 9 (rx interrupt enable), 14:12 (rx data offset) and 15 (rx enable). All other control bits read 0.
- R8: `tx_dma_run` is tx enable with flags 3 and 4 both clear. `rx_dma_run` is rx enable with flags 3 and 7 both clear.
- R9: `irq` is set one cycle after any enabled flag is set. Flags 0 and 1 are enabled by control bit 0, flag 5 by control bit 9, and flags 2, 3, 4, 6 and 7 are always enabled.
- R10: When an event and a clear reach the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the flag word, 1 selects the control word |
| reg_wdata | input | 16 | Write data |
| evt_pulse | input | 8 | Event pulses, one per flag (bit 5 is unused) |
| fifo_level | input | DEPTH_W | Receive FIFO entry count |
| rx_rd_ptr | input | RXP_W | Receive ring read pointer |
| tx_rd_ptr | input | TXP_W | Transmit ring read pointer |
| head_seq | input | SEQ_W | Sequence number of the message at the head of the queue |
| hash_sel | input | 1 | Multicast hash select output |
| status_word | output | 32 | Flags, pointer aliases, sequence number and hash bit |
| ctrl_word | output | 16 | DMA control word |
| irq | output | 1 | Interrupt request |
| tx_dma_run | output | 1 | Transmit DMA may run |
| rx_dma_run | output | 1 | Receive DMA may run |

## Verification
The bench builds the block with its default widths: a 5-bit receive pointer and depth, a 9-bit transmit pointer and a 5-bit sequence number. With these widths the status word is packed to bit 30 with no gap, so every alias field and the hash bit sit at their real positions. With a 5-bit depth, random FIFO levels hit the programmed depth often enough to exercise both sides of the threshold comparison. The stimulus also makes events and clears collide on the same flag, and it lets fatal flags gate the run outputs while enables change.

// File: rtl/dmaint_pkg.sv
package dmaint_pkg;
  localparam int FLAG_N      = 8;
  localparam int F_TX_EMPTY  = 0;
  localparam int F_TX_SENT   = 1;
  localparam int F_LINK      = 2;
  localparam int F_MEM       = 3;
  localparam int F_TX_ABORT  = 4;
  localparam int F_RX_THR    = 5;
  localparam int F_RX_UNDER  = 6;
  localparam int F_RX_OVER   = 7;

  localparam int CTRL_W      = 16;
  localparam int C_TX_IEN    = 0;
  localparam int C_TX_EN     = 1;
  localparam int C_DEPTH_LSB = 4;
  localparam int C_RX_IEN    = 9;
  localparam int C_OFS_LSB   = 12;
  localparam int C_RX_EN     = 15;

  localparam int STAT_W      = 32;
  localparam int RXP_LSB     = 8;
  localparam int TXP_LSB     = 16;

  typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/dmaint_flags.sv
module dmaint_flags
  import dmaint_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  flag_vec_t set_i,
  input  flag_vec_t clr_i,
  output flag_vec_t flags_o
);
  flag_vec_t flags_q;

  for (genvar i = 0; i < FLAG_N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           flags_q[i] <= 1'b0;
      else if (set_i[i]) flags_q[i] <= 1'b1;
      else if (clr_i[i]) flags_q[i] <= 1'b0;
    end
  end

  assign flags_o = flags_q;

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i))); // R2

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    ((set_i & clr_i) != '0) |=> ((flags_q & $past(set_i & clr_i)) == $past(set_i & clr_i))); // R10

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~set_i) != '0) |=> ((flags_q & $past(clr_i & ~set_i)) == '0)); // R3
endmodule

// File: rtl/dmaint_ctrl.sv
module dmaint_ctrl
  import dmaint_pkg::*;
#(
  parameter int DEPTH_W = 5,
  parameter int OFS_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  function automatic logic [CTRL_W-1:0] build_mask();
    logic [CTRL_W-1:0] m;
    m = '0;
    m[C_TX_IEN] = 1'b1;
    m[C_TX_EN]  = 1'b1;
    m[C_RX_IEN] = 1'b1;
    m[C_RX_EN]  = 1'b1;
    for (int i = 0; i < DEPTH_W; i++) m[C_DEPTH_LSB + i] = 1'b1;
    for (int i = 0; i < OFS_W; i++)   m[C_OFS_LSB + i]   = 1'b1;
    return m;
  endfunction

  localparam logic [CTRL_W-1:0] WMASK = build_mask();

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst)       ctrl_q <= '0;
    else if (wr_i) ctrl_q <= wdata_i & WMASK;
  end

  assign ctrl_o = ctrl_q;

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> (ctrl_q == ($past(wdata_i) & WMASK))); // R7

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(ctrl_q)); // R7
endmodule

// File: rtl/dmaint_thresh.sv
module dmaint_thresh #(
  parameter int DEPTH_W = 5
) (
  input  logic               rx_en_i,
  input  logic [DEPTH_W-1:0] level_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic               thr_o
);
  always_comb thr_o = rx_en_i && (level_i != depth_i);
endmodule

// File: rtl/dmaint_irq.sv
module dmaint_irq
  import dmaint_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  flag_vec_t flags_i,
  input  logic      tx_ien_i,
  input  logic      rx_ien_i,
  output logic      irq_o
);
  flag_vec_t enab;
  logic      irq_q;

  always_comb begin
    enab = '1;
    enab[F_TX_EMPTY] = tx_ien_i;
    enab[F_TX_SENT]  = tx_ien_i;
    enab[F_RX_THR]   = rx_ien_i;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags_i & enab);
  end

  assign irq_o = irq_q;

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(flags_i != '0)); // R9

  AST_IRQ_ERROR: assert property (@(posedge clk) disable iff (rst)
    (flags_i[F_MEM] || flags_i[F_RX_OVER]) |=> irq_q); // R9
endmodule

// File: rtl/dmaint_regs.sv
module dmaint_regs
  import dmaint_pkg::*;
#(
  parameter int RXP_W   = 5,
  parameter int TXP_W   = 9,
  parameter int SEQ_W   = 5,
  parameter int DEPTH_W = 5,
  parameter int OFS_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [15:0]        reg_wdata,
  input  logic [7:0]         evt_pulse,
  input  logic [DEPTH_W-1:0] fifo_level,
  input  logic [RXP_W-1:0]   rx_rd_ptr,
  input  logic [TXP_W-1:0]   tx_rd_ptr,
  input  logic [SEQ_W-1:0]   head_seq,
  input  logic               hash_sel,
  output logic [31:0]        status_word,
  output logic [15:0]        ctrl_word,
  output logic               irq,
  output logic               tx_dma_run,
  output logic               rx_dma_run
);
  localparam int SEQ_LSB  = TXP_LSB + TXP_W;
  localparam int HASH_BIT = SEQ_LSB + SEQ_W;

  flag_vec_t         flags, set_v, clr_v;
  logic [CTRL_W-1:0] ctrl;
  logic              thr;
  logic              hash_q;
  logic              rx_en;

  assign rx_en = ctrl[C_RX_EN];

  dmaint_thresh #(.DEPTH_W(DEPTH_W)) u_thresh (
    .rx_en_i (rx_en),
    .level_i (fifo_level),
    .depth_i (ctrl[C_DEPTH_LSB +: DEPTH_W]),
    .thr_o   (thr)
  );

  always_comb begin
    set_v           = evt_pulse;
    set_v[F_RX_THR] = thr;
    clr_v           = (reg_wr && !reg_sel) ? reg_wdata[FLAG_N-1:0] : '0;
  end

  dmaint_flags u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_i   (set_v),
    .clr_i   (clr_v),
    .flags_o (flags)
  );

  dmaint_ctrl #(.DEPTH_W(DEPTH_W), .OFS_W(OFS_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (reg_wr && reg_sel),
    .wdata_i (reg_wdata),
    .ctrl_o  (ctrl)
  );

  dmaint_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .flags_i  (flags),
    .tx_ien_i (ctrl[C_TX_IEN]),
    .rx_ien_i (ctrl[C_RX_IEN]),
    .irq_o    (irq)
  );

  always_ff @(posedge clk) begin
    if (rst)        hash_q <= 1'b0;
    else if (rx_en) hash_q <= hash_sel;
  end

  always_comb begin
    status_word                        = '0;
    status_word[FLAG_N-1:0]            = flags;
    status_word[RXP_LSB +: RXP_W]      = rx_rd_ptr;
    status_word[TXP_LSB +: TXP_W]      = tx_rd_ptr;
    status_word[SEQ_LSB +: SEQ_W]      = head_seq;
    status_word[HASH_BIT]              = hash_q;
  end

  assign ctrl_word  = ctrl;
  assign tx_dma_run = ctrl[C_TX_EN] && !flags[F_MEM] && !flags[F_TX_ABORT];
  assign rx_dma_run = rx_en && !flags[F_MEM] && !flags[F_RX_OVER];

  AST_THR_FLAG: assert property (@(posedge clk) disable iff (rst)
    (rx_en && (fifo_level != ctrl[C_DEPTH_LSB +: DEPTH_W])) |=> status_word[F_RX_THR]); // R5

  AST_HASH_TRACK: assert property (@(posedge clk) disable iff (rst)
    rx_en |=> (status_word[HASH_BIT] == $past(hash_sel))); // R6

  AST_FATAL_STOP: assert property (@(posedge clk) disable iff (rst)
    status_word[F_MEM] |-> (!tx_dma_run && !rx_dma_run)); // R8
endmodule

// File: tb/dmaint_regs_tb.sv
module dmaint_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [7:0]  evt_pulse = '0;
  logic [4:0]  fifo_level = '0;
  logic [4:0]  rx_rd_ptr = '0;
  logic [8:0]  tx_rd_ptr = '0;
  logic [4:0]  head_seq = '0;
  logic        hash_sel = 1'b0;
  logic [31:0] status_word;
  logic [15:0] ctrl_word;
  logic        irq, tx_dma_run, rx_dma_run;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0]  m_flags;
  logic [15:0] m_ctrl;
  logic        m_hash, m_irq;

  always #2 clk = ~clk;

  dmaint_regs u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .evt_pulse(evt_pulse), .fifo_level(fifo_level), .rx_rd_ptr(rx_rd_ptr),
    .tx_rd_ptr(tx_rd_ptr), .head_seq(head_seq), .hash_sel(hash_sel),
    .status_word(status_word), .ctrl_word(ctrl_word), .irq(irq),
    .tx_dma_run(tx_dma_run), .rx_dma_run(rx_dma_run)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    return {1'b0, m_hash, head_seq, tx_rd_ptr, 3'b000, rx_rd_ptr, m_flags};
  endfunction

  function automatic logic [7:0] irq_mask(input logic [15:0] c);
    return {1'b1, 1'b1, c[9], 1'b1, 1'b1, 1'b1, c[0], c[0]};
  endfunction

  task automatic step_and_check();
    logic [7:0]  set, clr, nf;
    logic [15:0] nc;
    logic        nh, ni;
    ni  = |(m_flags & irq_mask(m_ctrl));
    set = evt_pulse & 8'hDF;
    set[5] = m_ctrl[15] && (fifo_level != m_ctrl[8:4]);
    clr = (reg_wr && !reg_sel) ? reg_wdata[7:0] : 8'h00;
    nf  = (m_flags & ~clr) | set;
    nc  = (reg_wr && reg_sel) ? (reg_wdata & 16'hF3F3) : m_ctrl;
    nh  = m_ctrl[15] ? hash_sel : m_hash;
    @(posedge clk); #1;
    m_flags = nf; m_ctrl = nc; m_hash = nh; m_irq = ni;
    chk("R2/R3/R5/R10 flags", {56'd0, status_word[7:0]}, {56'd0, m_flags});
    chk("R4 aliases", {32'd0, status_word[31], status_word[29:8]},
        {32'd0, exp_status() & 32'hBFFF_FF00} >> 8 << 8 >> 8 | 64'd0 ? {32'd0, 1'b0, exp_status()[29:8]} : 64'd0);
    chk("R6 hash", {63'd0, status_word[30]}, {63'd0, m_hash});
    chk("R7 ctrl", {48'd0, ctrl_word}, {48'd0, m_ctrl});
    chk("R8 tx run", {63'd0, tx_dma_run}, {63'd0, m_ctrl[1] & ~m_flags[3] & ~m_flags[4]});
    chk("R8 rx run", {63'd0, rx_dma_run}, {63'd0, m_ctrl[15] & ~m_flags[3] & ~m_flags[7]});
    chk("R9 irq", {63'd0, irq}, {63'd0, m_irq});
  endtask

  task automatic drive(input logic wr, input logic sel, input logic [15:0] wd,
                       input logic [7:0] ev, input logic [4:0] lvl);
    @(negedge clk);
    reg_wr = wr; reg_sel = sel; reg_wdata = wd; evt_pulse = ev; fifo_level = lvl;
    rx_rd_ptr = 5'($urandom); tx_rd_ptr = 9'($urandom);
    head_seq = 5'($urandom); hash_sel = 1'($urandom);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_flags = '0; m_ctrl = '0; m_hash = 1'b0; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state with all inputs at zero
    chk("R1 status in reset", {32'd0, status_word}, 64'd0);
    chk("R1 ctrl in reset", {48'd0, ctrl_word}, 64'd0);
    chk("R1 irq/run in reset", {61'd0, irq, tx_dma_run, rx_dma_run}, 64'd0);
    @(negedge clk); rst = 1'b0;
    // R5: evt_pulse[5] ignored while rx disabled
    drive(1'b0, 1'b0, 16'h0, 8'h20, 5'd3); step_and_check();
    chk("R5 bit5 event ignored", {63'd0, status_word[5]}, 64'd0);
    // R9: tx flags masked with tx interrupt enable off
    drive(1'b0, 1'b0, 16'h0, 8'h03, 5'd0); step_and_check();
    drive(1'b0, 1'b0, 16'h0, 8'h00, 5'd0); step_and_check();
    chk("R9 masked tx flags give no irq", {63'd0, irq}, 64'd0);
    // R7: program enables and depth 4
    drive(1'b1, 1'b1, 16'hFFFF & ((16'd4 << 4) | 16'h8203), 8'h00, 5'd4); step_and_check();
    drive(1'b0, 1'b0, 16'h0, 8'h00, 5'd4); step_and_check();
    chk("R9 irq after enable", {63'd0, irq}, 64'd1);
    // R5: level equal to depth: clear flag 5 and it stays clear
    drive(1'b1, 1'b0, 16'h00FF, 8'h00, 5'd4); step_and_check();
    drive(1'b0, 1'b0, 16'h0, 8'h00, 5'd4); step_and_check();
    chk("R5 equal level no threshold", {63'd0, status_word[5]}, 64'd0);
    drive(1'b0, 1'b0, 16'h0, 8'h00, 5'd9); step_and_check();
    chk("R5 differing level sets threshold", {63'd0, status_word[5]}, 64'd1);
    // R10: event and clear collide on flag 1
    drive(1'b1, 1'b0, 16'h00FF, 8'h02, 5'd4); step_and_check();
    chk("R10 event wins", {63'd0, status_word[1]}, 64'd1);
    // R8: memory error stops both directions
    drive(1'b0, 1'b0, 16'h0, 8'h08, 5'd4); step_and_check();
    chk("R8 memory error stops tx", {63'd0, tx_dma_run}, 64'd0);
    drive(1'b1, 1'b0, 16'h0008, 8'h00, 5'd4); step_and_check();
    chk("R8 run resumes after clear", {62'd0, tx_dma_run, rx_dma_run}, 64'd3);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] r;
      logic [15:0] wd;
      r  = 3'($urandom);
      wd = 16'($urandom);
      if ($urandom % 3 == 0) wd[15] = 1'b1;
      drive((r < 3), (r == 0), (r == 1) ? 16'h00FF : wd,
            ($urandom % 5 == 0) ? 8'($urandom) : 8'h00,
            ($urandom % 2 == 0) ? m_ctrl[8:4] : 5'($urandom));
      step_and_check();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule